// File: doc/BRIEF.md
# Multichannel Serial ADC Scan Sequencer

This block drives a 12-bit successive-approximation converter that has a serial port and eleven analog inputs. A single start pulse makes it visit channels 0 through 10 in turn. In each serial frame it drives chip select, a divided serial clock and a data line that carries an 8-bit request word. On the same clock edges it captures the 12-bit result that the converter shifts back.

The converter always returns the result of the request made in the frame before. The sequencer therefore works one frame ahead. It drops the data from the opening frame of a scan and files the data of frame k under channel k-1. A twelfth frame, which carries a harmless request for channel 0, brings back the channel 10 result. When that frame ends, the scan is complete: busy drops and done pulses. A read port gives access to the stored results by channel.

Top module: `adc_scan_ctrl`

## Requirements
- R1: After reset, adc_cs_n is high, adc_sclk is low, busy and done are low, and every stored result reads as zero.
- R2: A start pulse while idle raises busy on the next cycle. A start pulse while busy is ignored: the scan runs its normal twelve frames and gives a single done. Once idle, the block starts no frame until the next start.
- R3: Each frame opens with adc_cs_n high and then low while adc_sclk stays low. The frame has exactly 12 adc_sclk pulses, and adc_sclk is high only while adc_cs_n is low. adc_cs_n returns high after the last pulse.
- R4: The request word is sent MSB first on the first 8 rising edges. Bits [7:4] carry the channel number in binary. Bits [3:2] carry the 12-bit length code, which is 00 by default and 10 when ALT_LEN=1. Bits [1:0] are 00 for MSB-first output. adc_mosi is held stable while adc_sclk is high, and it is low for the last 4 pulses.
- R5: One scan sends exactly twelve frames. The first eleven request channels 0,1,…,10 in order, and the twelfth requests channel 0 as a dummy.
- R6: adc_miso is sampled at each rising adc_sclk edge. The 12 samples assemble the result MSB first.
- R7: The data captured in frame k (k ≥ 1) is stored as the result of channel k-1. The data of frame 0 is discarded and never written anywhere.
- R8: done is a single-cycle pulse that rises on the same edge on which busy falls, at the end of the twelfth frame.
- R9: Each adc_sclk high phase lasts exactly DIV system clocks. Every low phase lasts at least DIV clocks.
- R10: rd_data returns the stored result of channel rd_ch without delay. For rd_ch values of 11 and above it returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Scan start pulse |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at scan completion |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock |
| adc_mosi | output | 1 | Request word toward the converter |
| adc_miso | input | 1 | Result data from the converter |
| rd_ch | input | 4 | Result read channel |
| rd_data | output | 12 | Stored result of rd_ch |

## Verification
The checker watches the serial framing on every cycle. It confirms that the clock is gated by chip select, that each frame closes after exactly twelve pulses, that the data line holds still while the clock is high, and that each high phase lasts DIV clocks. It also confirms that busy is held until done and that done never overlaps busy. The following can only be shown by the bench scenarios, which run against a behavioural converter that answers one frame late: the channel order and the dummy request, the length and order bits of the request word, the one-frame offset in filing, and the discarding of the opening frame's stale word.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   localparam int CH_W  = 4;
   localparam int LEN_W = 2;
   localparam int ORD_W = 2;
   localparam int CTL_W = CH_W + LEN_W + ORD_W;

   localparam logic [LEN_W-1:0] LEN12_STD = 2'b00;
   localparam logic [LEN_W-1:0] LEN12_ALT = 2'b10;
   localparam logic [ORD_W-1:0] ORD_MSB   = 2'b00;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_CSH,
      PH_SETUP,
      PH_HI,
      PH_LO,
      PH_END
   } phase_t;

   function automatic logic [CTL_W-1:0] make_ctl(input logic [CH_W-1:0] ch,
                                                 input logic [LEN_W-1:0] len);
      return {ch, len, ORD_MSB};
   endfunction

endpackage

// File: rtl/adc_scan_tick.sv
module adc_scan_tick #(
   parameter int DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] cnt;

   assign tick = (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/adc_scan_frame.sv
module adc_scan_frame
   import adc_scan_pkg::*;
#(
   parameter int RES_W = 12,
   parameter int DIV   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [CTL_W-1:0] ctl,
   input  logic             miso,
   output logic             cs_n,
   output logic             sclk,
   output logic             mosi,
   output logic [RES_W-1:0] rx,
   output logic             frame_done
);
   localparam int PAD = RES_W - CTL_W;
   localparam int BCW = $clog2(RES_W);
   localparam logic [BCW-1:0] LAST = BCW'(RES_W - 1);

   generate
      if (PAD < 0) begin : g_bad_width
         $error("adc_scan_frame: result width shorter than request word");
      end
      if (DIV < 1) begin : g_bad_div
         $error("adc_scan_frame: DIV must be at least 1");
      end
   endgenerate

   phase_t           ph;
   logic             tick;
   logic [RES_W-1:0] tx;
   logic [BCW-1:0]   bcnt;

   adc_scan_tick #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ph == PH_IDLE),
      .tick  (tick)
   );

   assign mosi       = tx[RES_W-1];
   assign frame_done = (ph == PH_END) && tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph   <= PH_IDLE;
         cs_n <= 1'b1;
         sclk <= 1'b0;
         tx   <= '0;
         rx   <= '0;
         bcnt <= '0;
      end else begin
         unique case (ph)
            PH_IDLE: begin
               if (go) begin
                  ph <= PH_CSH;
                  tx <= RES_W'(ctl) << PAD;
               end
            end
            PH_CSH: begin
               if (tick) begin
                  ph   <= PH_SETUP;
                  cs_n <= 1'b0;
               end
            end
            PH_SETUP: begin
               if (tick) begin
                  rx   <= {rx[RES_W-2:0], miso};
                  sclk <= 1'b1;
                  bcnt <= '0;
                  ph   <= PH_HI;
               end
            end
            PH_HI: begin
               if (tick) begin
                  sclk <= 1'b0;
                  if (bcnt == LAST) begin
                     ph   <= PH_END;
                     cs_n <= 1'b1;
                  end else begin
                     ph <= PH_LO;
                     tx <= {tx[RES_W-2:0], 1'b0};
                  end
               end
            end
            PH_LO: begin
               if (tick) begin
                  rx   <= {rx[RES_W-2:0], miso};
                  sclk <= 1'b1;
                  bcnt <= bcnt + 1'b1;
                  ph   <= PH_HI;
               end
            end
            PH_END: begin
               if (tick)
                  ph <= PH_IDLE;
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs #(
   parameter int NCH   = 11,
   parameter int RES_W = 12,
   parameter int IW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IW-1:0]    wa,
   input  logic [RES_W-1:0] wd,
   input  logic [IW-1:0]    ra,
   output logic [RES_W-1:0] rd
);
   logic [NCH*RES_W-1:0] flat;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_slot
         logic [RES_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (wa == IW'(g)))
               q <= wd;
         end
         assign flat[g*RES_W +: RES_W] = q;
      end
   endgenerate

   always_comb begin
      rd = '0;
      for (int i = 0; i < NCH; i++)
         if (ra == IW'(i))
            rd = flat[i*RES_W +: RES_W];
   end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int NCH     = 11,
   parameter int RES_W   = 12,
   parameter int DIV     = 2,
   parameter bit ALT_LEN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic             adc_cs_n,
   output logic             adc_sclk,
   output logic             adc_mosi,
   input  logic             adc_miso,
   input  logic [CH_W-1:0]  rd_ch,
   output logic [RES_W-1:0] rd_data
);
   localparam int FW = $clog2(NCH + 2);

   generate
      if (NCH < 2 || NCH > (1 << CH_W)) begin : g_bad_nch
         $error("adc_scan_ctrl: NCH out of range for channel field");
      end
   endgenerate

   logic [LEN_W-1:0] len_code;
   generate
      if (ALT_LEN) begin : g_len_alt
         assign len_code = LEN12_ALT;
      end else begin : g_len_std
         assign len_code = LEN12_STD;
      end
   endgenerate

   logic [FW-1:0]    idx;
   logic             launch;
   logic             fdone;
   logic [RES_W-1:0] rx;
   logic [CH_W-1:0]  req_ch;
   logic [CTL_W-1:0] ctl;
   logic             we;
   logic [CH_W-1:0]  wa;

   // Frames 0..NCH-1 request their own channel; the trailing frame asks for 0.
   assign req_ch = (idx < FW'(NCH)) ? CH_W'(idx) : '0;
   assign ctl    = make_ctl(req_ch, len_code);

   // Data arriving in frame k answers the request of frame k-1.
   assign we = busy && fdone && (idx != '0);
   assign wa = CH_W'(idx - FW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         launch <= 1'b0;
         idx    <= '0;
      end else begin
         done   <= 1'b0;
         launch <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy   <= 1'b1;
               idx    <= '0;
               launch <= 1'b1;
            end
         end else if (fdone) begin
            if (idx == FW'(NCH)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               idx    <= idx + 1'b1;
               launch <= 1'b1;
            end
         end
      end
   end

   adc_scan_frame #(.RES_W(RES_W), .DIV(DIV)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (launch),
      .ctl        (ctl),
      .miso       (adc_miso),
      .cs_n       (adc_cs_n),
      .sclk       (adc_sclk),
      .mosi       (adc_mosi),
      .rx         (rx),
      .frame_done (fdone)
   );

   adc_scan_regs #(.NCH(NCH), .RES_W(RES_W), .IW(CH_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we),
      .wa    (wa),
      .wd    (rx),
      .ra    (rd_ch),
      .rd    (rd_data)
   );

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int RES_W = 12,
   parameter int DIV   = 2
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic adc_cs_n,
   input logic adc_sclk,
   input logic adc_mosi
);
   logic sclk_q;
   int   rise_cnt;
   int   hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         rise_cnt <= 0;
         hi_cnt   <= 0;
      end else begin
         sclk_q <= adc_sclk;
         if (adc_cs_n)
            rise_cnt <= 0;
         else if (adc_sclk && !sclk_q)
            rise_cnt <= rise_cnt + 1;
         hi_cnt <= adc_sclk ? hi_cnt + 1 : 0;
      end
   end

   assert_sclk_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adc_sclk |-> !adc_cs_n);

   assert_pulse_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(adc_cs_n) |-> (rise_cnt == RES_W));

   assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adc_sclk |-> $stable(adc_mosi));

   assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (adc_cs_n && !adc_sclk));

   assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   assert_high_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(adc_sclk) |-> (hi_cnt == DIV));

endmodule

bind adc_scan_ctrl adc_scan_chk #(.RES_W(RES_W), .DIV(DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .adc_cs_n (adc_cs_n),
   .adc_sclk (adc_sclk),
   .adc_mosi (adc_mosi)
);

// File: tb/adc_scan_ctrl_bench.sv
module adc_scan_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 11;
   localparam int NFR   = NCH + 1;
   localparam logic [11:0] JUNK = 12'h5A5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        busy, done;
   logic        adc_cs_n, adc_sclk, adc_mosi, adc_miso;
   logic [3:0]  rd_ch = 4'd0;
   logic [11:0] rd_data;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_scan_ctrl u_adc_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_mosi(adc_mosi),
      .adc_miso(adc_miso), .rd_ch(rd_ch), .rd_data(rd_data)
   );

   // Behavioural converter: answers each request one frame late.
   logic [11:0] chv [NCH];
   logic [11:0] prev = JUNK;
   logic [11:0] osh = 12'h0;
   logic [7:0]  ish = 8'h0;
   int          nclk = 0;
   int          nframes = 0;
   int          tail_err = 0;
   int          ndone = 0;
   logic [7:0]  ctl_log [16];
   int          clk_log [16];

   assign adc_miso = osh[11];

   always @(negedge adc_cs_n) begin
      osh  = prev;
      nclk = 0;
   end
   always @(posedge adc_sclk) begin
      if (nclk < 8) ish = {ish[6:0], adc_mosi};
      else if (adc_mosi) tail_err++;
      nclk++;
   end
   always @(negedge adc_sclk) if (!adc_cs_n) osh = {osh[10:0], 1'b0};
   always @(posedge adc_cs_n) begin
      if (nframes < 16) begin
         ctl_log[nframes] = ish;
         clk_log[nframes] = nclk;
      end
      nframes++;
      prev = (ish[7:4] < 4'd11) ? chv[ish[7:4]] : 12'h000;
   end
   always @(posedge clk) if (done) ndone++;

   function automatic logic [7:0] exp_ctl(input int k);
      logic [3:0] ch;
      ch = (k < NCH) ? 4'(k) : 4'd0;
      return {ch, 2'b00, 2'b00};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic read_ch(input int c, output logic [11:0] v);
      rd_ch = 4'(c);
      #1;
      v = rd_data;
   endtask

   task automatic run_scan(input bit poke_mid);
      bit seen;
      logic [11:0] v;
      nframes = 0; tail_err = 0; ndone = 0; prev = JUNK;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      seen = 1'b0;
      for (int cyc = 0; cyc < 20000 && !seen; cyc++) begin
         @(negedge clk);
         if (poke_mid && (cyc == 300 || cyc == 301)) start = (cyc == 300);
         if (done) seen = 1'b1;
      end
      start = 1'b0;
      check(seen, "R8", "done seen", int'(seen), 1);
      check(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
      @(negedge clk);
      check(done == 1'b0, "R8", "done one cycle", int'(done), 0);
      check(ndone == 1, "R2", "done count", ndone, 1);
      check(nframes == NFR, "R5", "frame count", nframes, NFR);
      for (int k = 0; k < NFR; k++) begin
         check(ctl_log[k] == exp_ctl(k), "R4", "request word", int'(ctl_log[k]),
               int'(exp_ctl(k)));
         check(clk_log[k] == 12, "R3", "pulses per frame", clk_log[k], 12);
      end
      check(tail_err == 0, "R4", "mosi low on tail", tail_err, 0);
      for (int c = 0; c < NCH; c++) begin
         read_ch(c, v);
         check(v == chv[c], "R7", "stored result", int'(v), int'(chv[c]));
         check(v != JUNK, "R7", "first frame dropped", int'(v), int'(chv[c]));
      end
      for (int c = NCH; c < 16; c++) begin
         read_ch(c, v);
         check(v == 12'h0, "R10", "out of range read", int'(v), 0);
      end
      repeat (200) @(negedge clk);
      check(nframes == NFR, "R2", "no frame while idle", nframes, NFR);
   endtask

   initial begin
      logic [11:0] v;
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(adc_cs_n == 1'b1, "R1", "cs_n at reset", int'(adc_cs_n), 1);
      check(adc_sclk == 1'b0, "R1", "sclk at reset", int'(adc_sclk), 0);
      check(busy == 1'b0 && done == 1'b0, "R1", "busy/done at reset",
            int'({busy, done}), 0);
      for (int c = 0; c < NCH; c++) begin
         read_ch(c, v);
         check(v == 12'h0, "R1", "result at reset", int'(v), 0);
      end
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Directed: extremes and alternating patterns (R6 bit order)
      for (int c = 0; c < NCH; c++)
         chv[c] = (c == 0) ? 12'hFFF : (c == 1) ? 12'h000 :
                  (c[0] ? 12'hAAA : 12'h555) ^ 12'(c);
      run_scan(1'b0);

      // Random values, with a start pulse injected mid-scan (R2)
      for (int s = 0; s < 3; s++) begin
         for (int c = 0; c < NCH; c++) begin
            chv[c] = 12'($urandom_range(0, 4095));
            if (chv[c] == JUNK) chv[c] = ~JUNK;
         end
         run_scan(s == 1);
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule